// File: doc/BRIEF.md
# Subtraction-Based Compare Unit

This block orders two operands of a general-purpose datapath and returns a condition nibble that a later stage can write into a condition register field. Its adder forms the inverse of A, plus B, plus one, which equals B minus A. The carry out, the top bit of that difference and the top bits of the operands together give "less than" and "greater than". Equality comes from a separate direct comparison of the two operands. It does not test the difference for zero.

One `signed_i` flag chooses signed or unsigned ordering. One `wide_i` flag chooses between the full operand width and the low half. In the narrow mode the carry out of the low segment and the bit below the segment boundary are used, and the upper bits of both operands play no part. A summary-overflow flag arrives on `so_i` and is copied into the lowest bit of the result. The unit is purely combinational, so a caller can place it inside any pipeline stage.

Top module: `cmpu_top`

## Requirements
- R1: `cond_o` is packed with LT at bit 3, GT at bit 2, EQ at bit 1 and SO at bit 0. For every input, exactly one of LT, GT and EQ is 1.
- R2: `cond_o[0]` always equals `so_i`.
- R3: EQ is 1 exactly when the operands are equal over the active width. With `wide_i`=1 the active width is all DATA_W bits. With `wide_i`=0 it is the low NARROW_W bits.
- R4: With `signed_i`=0, LT is 1 exactly when A is below B as unsigned numbers over the active width.
- R5: With `signed_i`=1, LT is 1 exactly when A is below B in two's complement over the active width. In narrow mode the sign is bit NARROW_W-1.
- R6: GT is 1 exactly when neither LT nor EQ is 1.
- R7: With `wide_i`=0, changing bits DATA_W-1 down to NARROW_W of either operand leaves `cond_o` unchanged.
- R8: The unit holds no state. `cond_o` reflects the present inputs within the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W | First operand (A) |
| b_i | input | DATA_W | Second operand (B) |
| signed_i | input | 1 | 1 selects two's complement ordering |
| wide_i | input | 1 | 1 compares all DATA_W bits, 0 compares the low NARROW_W bits |
| so_i | input | 1 | Summary-overflow flag, copied into the result |
| cond_o | output | 4 | {LT, GT, EQ, SO} |

## Verification
The block holds no state, so any fault shows up at `cond_o` in the same cycle as the stimulus that exposes it. Some faults show up only for particular operands:
- A wrong carry or segment split changes the order only when the operands differ in the upper segment, or across the segment boundary.
- A wrong sign decode shows up only when the two top bits differ.
- A broken equality path shows up as two flags set at once, or as a narrow-mode result that moves when only upper bits change.

For these reasons the stimulus covers equal operands, operands that differ only in the upper bits, and extreme values of both signs.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

   // Condition nibble as written into a condition field: LT is the MSB.
   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cmpu_cond_t;

   localparam int unsigned COND_W = $bits(cmpu_cond_t);

endpackage

// File: rtl/cmpu_sub.sv
// Single adder forming ~A + B + 1, with a carry tap at the narrow boundary.
module cmpu_sub #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] diff_o,
   output logic              c_narrow_o,
   output logic              c_wide_o
);
   localparam int unsigned HI_W = DATA_W - NARROW_W;

   generate
      if (HI_W > 0) begin : g_split
         logic [NARROW_W:0] lo_sum;
         logic [HI_W:0]     hi_sum;
         assign lo_sum = {1'b0, ~a_i[NARROW_W-1:0]} + {1'b0, b_i[NARROW_W-1:0]}
                       + (NARROW_W+1)'(1);
         assign hi_sum = {1'b0, ~a_i[DATA_W-1:NARROW_W]} + {1'b0, b_i[DATA_W-1:NARROW_W]}
                       + (HI_W+1)'(lo_sum[NARROW_W]);
         assign diff_o     = {hi_sum[HI_W-1:0], lo_sum[NARROW_W-1:0]};
         assign c_narrow_o = lo_sum[NARROW_W];
         assign c_wide_o   = hi_sum[HI_W];
      end else begin : g_flat
         logic [DATA_W:0] sum;
         assign sum        = {1'b0, ~a_i} + {1'b0, b_i} + (DATA_W+1)'(1);
         assign diff_o     = sum[DATA_W-1:0];
         assign c_narrow_o = sum[DATA_W];
         assign c_wide_o   = sum[DATA_W];
      end
   endgenerate
endmodule

// File: rtl/cmpu_eq.sv
// Direct operand equality; the upper segment is masked in narrow mode.
module cmpu_eq #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              wide_i,
   output logic              eq_o
);
   localparam int unsigned HI_W = DATA_W - NARROW_W;

   logic lo_match;
   assign lo_match = (a_i[NARROW_W-1:0] == b_i[NARROW_W-1:0]);

   generate
      if (HI_W > 0) begin : g_split
         logic hi_match;
         assign hi_match = (a_i[DATA_W-1:NARROW_W] == b_i[DATA_W-1:NARROW_W]);
         assign eq_o     = lo_match & (hi_match | ~wide_i);
      end else begin : g_flat
         logic unused_wide;
         assign unused_wide = wide_i;
         assign eq_o        = lo_match;
      end
   endgenerate
endmodule

// File: rtl/cmpu_order.sv
// Derives LT/GT from carry, difference MSB and operand MSBs.
module cmpu_order (
   input  logic signed_i,
   input  logic wide_i,
   input  logic a_msb_n_i,
   input  logic a_msb_w_i,
   input  logic b_msb_n_i,
   input  logic b_msb_w_i,
   input  logic d_msb_n_i,
   input  logic d_msb_w_i,
   input  logic c_n_i,
   input  logic c_w_i,
   input  logic eq_i,
   output logic lt_o,
   output logic gt_o
);
   logic a_msb, b_msb, d_msb, carry, below;

   always_comb begin
      a_msb = wide_i ? a_msb_w_i : a_msb_n_i;
      b_msb = wide_i ? b_msb_w_i : b_msb_n_i;
      d_msb = wide_i ? d_msb_w_i : d_msb_n_i;
      carry = wide_i ? c_w_i     : c_n_i;
      if (signed_i && (a_msb != b_msb))
         below = a_msb;          // negative A against non-negative B
      else if (signed_i)
         below = ~d_msb;         // same sign: B-A cannot overflow
      else
         below = carry;          // unsigned: carry set means B >= A
      lt_o = below & ~eq_i;
      gt_o = ~below & ~eq_i;
   end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              signed_i,
   input  logic              wide_i,
   input  logic              so_i,
   output logic [3:0]        cond_o
);
   import cmpu_pkg::*;

   generate
      if (NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_width
         $error("cmpu_top: NARROW_W must lie in 1..DATA_W");
      end
      if (COND_W != 4) begin : g_bad_cond
         $error("cmpu_top: condition nibble must be 4 bits");
      end
   endgenerate

   logic [DATA_W-1:0] diff;
   logic              c_narrow, c_wide, eq, lt, gt;
   cmpu_cond_t        cond;

   cmpu_sub #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_sub (
      .a_i        (a_i),
      .b_i        (b_i),
      .diff_o     (diff),
      .c_narrow_o (c_narrow),
      .c_wide_o   (c_wide)
   );

   cmpu_eq #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_eq (
      .a_i    (a_i),
      .b_i    (b_i),
      .wide_i (wide_i),
      .eq_o   (eq)
   );

   cmpu_order u_order (
      .signed_i  (signed_i),
      .wide_i    (wide_i),
      .a_msb_n_i (a_i[NARROW_W-1]),
      .a_msb_w_i (a_i[DATA_W-1]),
      .b_msb_n_i (b_i[NARROW_W-1]),
      .b_msb_w_i (b_i[DATA_W-1]),
      .d_msb_n_i (diff[NARROW_W-1]),
      .d_msb_w_i (diff[DATA_W-1]),
      .c_n_i     (c_narrow),
      .c_w_i     (c_wide),
      .eq_i      (eq),
      .lt_o      (lt),
      .gt_o      (gt)
   );

   always_comb begin
      cond.lt = lt;
      cond.gt = gt;
      cond.eq = eq;
      cond.so = so_i;
      cond_o  = cond;
   end
endmodule

// File: rtl/cmpu_chk.sv
module cmpu_chk #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic              signed_i,
   input logic              wide_i,
   input logic              so_i,
   input logic [3:0]        cond_o
);
   logic signed [DATA_W:0] ax, bx;

   always_comb begin
      if (wide_i) begin
         ax = {signed_i & a_i[DATA_W-1], a_i};
         bx = {signed_i & b_i[DATA_W-1], b_i};
      end else begin
         ax = '0;
         bx = '0;
         for (int i = 0; i <= DATA_W; i++) begin
            ax[i] = (i < NARROW_W) ? a_i[i] : (signed_i & a_i[NARROW_W-1]);
            bx[i] = (i < NARROW_W) ? b_i[i] : (signed_i & b_i[NARROW_W-1]);
         end
      end
   end

   always_comb begin
      a_r1_one_flag: assert ($onehot(cond_o[3:1]))
         else $error("R1: LT/GT/EQ not exactly one");
      a_r2_so_copy: assert (cond_o[0] == so_i)
         else $error("R2: SO not copied");
      a_r3_eq_width: assert (cond_o[1] == (ax == bx))
         else $error("R3: EQ wrong for active width");
      a_r4_r5_lt_order: assert (cond_o[3] == (ax < bx))
         else $error("R4/R5: LT disagrees with ordering");
      a_r6_gt_rest: assert (cond_o[2] == (ax > bx))
         else $error("R6: GT disagrees with ordering");
   end
endmodule

bind cmpu_top cmpu_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cmpu_chk (
   .a_i      (a_i),
   .b_i      (b_i),
   .signed_i (signed_i),
   .wide_i   (wide_i),
   .so_i     (so_i),
   .cond_o   (cond_o)
);

// File: tb/tb_cmpu_top.sv
module tb_cmpu_top;
   localparam int unsigned DATA_W   = 64;
   localparam int unsigned NARROW_W = 32;
   localparam time CLK_PERIOD = 10ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] a, b;
   logic              sg, wd, so;
   logic [3:0]        cond;

   int unsigned n_run  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmpu_top #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) dut (
      .a_i(a), .b_i(b), .signed_i(sg), .wide_i(wd), .so_i(so), .cond_o(cond)
   );

   // Behavioural reference: extend to one extra bit and use native ordering.
   function automatic logic [3:0] model(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                                        input logic s, input logic w, input logic f);
      logic signed [DATA_W:0] ex, ey;
      if (w) begin
         ex = {s & x[DATA_W-1], x};
         ey = {s & y[DATA_W-1], y};
      end else begin
         ex = {{(DATA_W-NARROW_W+1){s & x[NARROW_W-1]}}, x[NARROW_W-1:0]};
         ey = {{(DATA_W-NARROW_W+1){s & y[NARROW_W-1]}}, y[NARROW_W-1:0]};
      end
      return {ex < ey, ex > ey, ex == ey, f};
   endfunction

   // Drive on the falling edge, sample before the next rising edge (R8: same cycle).
   task automatic apply(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                        input logic s, input logic w, input logic f, input string tag);
      logic [3:0] exp;
      @(negedge clk);
      a = x; b = y; sg = s; wd = w; so = f;
      exp = model(x, y, s, w, f);
      #(CLK_PERIOD/4);
      n_run++;
      if (cond !== exp) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h s=%0b w=%0b actual=%b expected=%b", tag, x, y, s, w, cond, exp);
      end
   endtask

   // R7: two narrow-mode results that differ only in upper bits must match.
   task automatic upper_ignored(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y, input logic s);
      logic [3:0] first;
      @(negedge clk);
      a = x; b = y; sg = s; wd = 1'b0; so = 1'b0;
      #(CLK_PERIOD/4);
      first = cond;
      @(negedge clk);
      a = {~x[DATA_W-1:NARROW_W], x[NARROW_W-1:0]};
      b = {y[DATA_W-1:NARROW_W] ^ 32'h5A5A_00FF, y[NARROW_W-1:0]};
      #(CLK_PERIOD/4);
      n_run++;
      if (cond !== first) begin
         n_fail++;
         $display("FAIL R7: upper bits changed result actual=%b expected=%b", cond, first);
      end
   endtask

   initial begin
      a = '0; b = '0; sg = 1'b0; wd = 1'b1; so = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: zero operands give EQ only, flags packed LT,GT,EQ,SO
      @(negedge clk);
      n_run++;
      if (cond !== 4'b0010) begin
         n_fail++;
         $display("FAIL R1: idle actual=%b expected=%b", cond, 4'b0010);
      end
      apply(64'd5, 64'd5, 1'b0, 1'b1, 1'b1, "R2");
      apply(64'd3, 64'd9, 1'b0, 1'b1, 1'b0, "R4");
      apply(64'd9, 64'd3, 1'b0, 1'b1, 1'b0, "R6");
      apply('1, 64'd0, 1'b0, 1'b1, 1'b0, "R4");
      apply('1, 64'd0, 1'b1, 1'b1, 1'b0, "R5");
      apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, "R5");
      apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, "R4");
      apply(64'hDEAD_0000_1234_5678, 64'h0000_BEEF_1234_5678, 1'b0, 1'b0, 1'b0, "R3");
      apply(64'hDEAD_0000_1234_5678, 64'h0000_BEEF_1234_5678, 1'b0, 1'b1, 1'b0, "R3");
      apply(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0, "R5");
      apply(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0, "R4");
      apply(64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1, 1'b0, "R6");
      apply(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, "R5");
      upper_ignored(64'h1111_2222_0000_0010, 64'h3333_4444_FFFF_FFF0, 1'b1);
      upper_ignored(64'h1111_2222_0000_0010, 64'h3333_4444_FFFF_FFF0, 1'b0);
      upper_ignored(64'h9999_0000_ABCD_0000, 64'h0000_7777_ABCD_0000, 1'b0);
      for (int i = 0; i < 400; i++) begin
         logic [DATA_W-1:0] x, y;
         logic s, w;
         x = {$urandom, $urandom};
         y = {$urandom, $urandom};
         if (i % 5 == 0) y = x;
         if (i % 7 == 0) y = {~x[DATA_W-1:NARROW_W], x[NARROW_W-1:0]};
         if (i % 11 == 0) y = x + 64'd1;
         s = i[0];
         w = i[1];
         apply(x, y, s, w, i[2], s ? "R5" : "R4");
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule